// File: doc/BRIEF.md
# Flash command register interface

This block is the memory-side command decoder of a byte-wide flash device, written as synchronous logic. The chip-enable, write-enable and output-enable strobes are active low and are sampled on the system clock. A bus write is taken on the first clock where write-enable is seen low after being high, with chip-enable low and output-enable high. The write updates a command state that decides what later reads return: array bytes, identifier codes, or the byte at an address latched for verification. It also issues chip-erase and byte-program requests to a small behavioural array, and raises a busy flag for a parameterised number of cycles after each request.

A single input, `prog_hv_i`, marks that the high-voltage program supply is present. Without it, writes have no effect and the block only reads the array. A second input, `id_hv_i`, stands for the high-voltage level on address line 9. When it is set during a read, the identifier codes are returned no matter which command is active. Reads are combinational from the command state and the array. `rd_oe_o` marks the cycles where `rd_data_o` carries data, and `rd_data_o` is zero otherwise.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the array holds FFH in every byte, the mode is array read, `busy_o` is low, and `rd_oe_o` is low while no read strobe is applied.
- R2: Writing 00H or FFH selects array read: a read returns the array byte at `addr_i`.
- R3: Writing 80H or 90H selects identifier mode: a read returns 89H when `addr_i` bit 0 is 0 and `DEV_ID` (default B4H) when it is 1.
- R4: 20H written in two consecutive accepted writes erases the whole array to FFH and holds `busy_o` high for exactly `ERASE_CYC` cycles.
- R5: 20H followed by any byte other than 20H leaves the array unchanged, raises no busy, and returns to array read.
- R6: 40H followed by a write of address PA and data PD stores old AND PD at PA, so bits can only be cleared, and holds `busy_o` high for exactly `PROG_CYC` cycles.
- R7: Writing A0H at address EA selects erase verify: every read returns the byte at EA, whatever `addr_i` is.
- R8: Writing C0H selects program verify: every read returns the byte at the address latched by the last program data write.
- R9: Two consecutive FFH writes return to array read from any mode, including erase-armed and program-armed, without changing the array.
- R10: While `prog_hv_i` is low, writes are ignored, the mode is held at array read, and the array is not changed.
- R11: A read with `id_hv_i` high returns 89H or `DEV_ID` selected by `addr_i` bit 0 alone, in every mode.
- R12: Writes made while `busy_o` is high are ignored, and no erase or program request is issued while busy.
- R13: Holding write-enable low over several clocks counts as one write.

Summary of the command byte values: 00H and FFH select array read, 80H and 90H select identifier mode, 20H arms erase, A0H selects erase verify, 40H arms program, and C0H selects program verify. Any other byte written in array read, identifier or verify mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Byte address |
| data_i | input | 8 | Write data / command byte |
| prog_hv_i | input | 1 | Program supply high; erase and program are allowed only when this is set |
| id_hv_i | input | 1 | High voltage present on address line 9; forces identifier reads |
| rd_data_o | output | 8 | Read data, zero when not reading |
| rd_oe_o | output | 1 | Read data valid (chip enable and output enable low, write enable high) |
| busy_o | output | 1 | Erase or program in progress |

## Verification
The assertions assume that strobe changes are synchronous to the clock. They also assume that `prog_hv_i` holds steady across the cycle in which a write is taken, so that the mode-stability property while busy sees one supply value at each edge. The bench drives every input on the falling clock edge. It holds each write for one full cycle with write-enable low and then returns it high, and it changes `prog_hv_i` and `id_hv_i` only while the strobes are idle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MD_ARRAY,
    MD_IDENT,
    MD_ERASE_ARM,
    MD_ERASE_VFY,
    MD_PROG_ARM,
    MD_PROG_VFY
  } flash_mode_e;

  localparam logic [7:0] OP_RD_A  = 8'h00;
  localparam logic [7:0] OP_RD_B  = 8'hFF;
  localparam logic [7:0] OP_ID_A  = 8'h80;
  localparam logic [7:0] OP_ID_B  = 8'h90;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_EVFY  = 8'hA0;
  localparam logic [7:0] OP_PROG  = 8'h40;
  localparam logic [7:0] OP_PVFY  = 8'hC0;

  localparam logic [7:0] MFG_CODE = 8'h89;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          prog_hv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output flash_mode_e   mode_o,
  output logic [AW-1:0] evfy_addr_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [7:0]    prog_data_o,
  output logic          erase_req_o,
  output logic          prog_req_o
);

  flash_mode_e   mode_q, mode_d;
  logic [AW-1:0] evfy_q, evfy_d;
  logic [AW-1:0] pa_q, pa_d;

  always_comb begin
    mode_d      = mode_q;
    evfy_d      = evfy_q;
    pa_d        = pa_q;
    erase_req_o = 1'b0;
    prog_req_o  = 1'b0;
    if (wr_i) begin
      unique case (mode_q)
        MD_ERASE_ARM: begin
          mode_d = MD_ARRAY;
          if (data_i == OP_ERASE) erase_req_o = 1'b1;
        end
        MD_PROG_ARM: begin
          mode_d = MD_ARRAY;
          if (data_i != OP_RD_B) begin
            prog_req_o = 1'b1;
            pa_d       = addr_i;
          end
        end
        default: begin
          unique case (data_i)
            OP_RD_A, OP_RD_B: mode_d = MD_ARRAY;
            OP_ID_A, OP_ID_B: mode_d = MD_IDENT;
            OP_ERASE:         mode_d = MD_ERASE_ARM;
            OP_EVFY: begin
              mode_d = MD_ERASE_VFY;
              evfy_d = addr_i;
            end
            OP_PROG:          mode_d = MD_PROG_ARM;
            OP_PVFY:          mode_d = MD_PROG_VFY;
            default:          mode_d = mode_q;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_ARRAY;
      evfy_q <= '0;
      pa_q   <= '0;
    end else if (!prog_hv_i) begin
      mode_q <= MD_ARRAY;
    end else begin
      mode_q <= mode_d;
      evfy_q <= evfy_d;
      pa_q   <= pa_d;
    end
  end

  assign mode_o      = mode_q;
  assign evfy_addr_o = evfy_q;
  assign prog_addr_o = pa_d;
  assign prog_data_o = data_i;

  // R10
  supply_low_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_hv_i |=> mode_q == MD_ARRAY);

  // R12
  idle_mode_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && prog_hv_i) |=> $stable(mode_q));

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic erase_req_i,
  input  logic prog_req_i,
  output logic busy_o
);

  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (erase_req_i) cnt_q <= CW'(ERASE_CYC);
    else if (prog_req_i)  cnt_q <= CW'(PROG_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = cnt_q != '0;

  // R4
  erase_busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_i |=> busy_o && cnt_q == CW'(ERASE_CYC));

  // R6
  prog_busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_i && !erase_req_i) |=> busy_o && cnt_q == CW'(PROG_CYC));

  // R12
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAXC));

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_req_i,
  input  logic          prog_req_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [7:0]    prog_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_req_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (prog_req_i) begin
      mem_q[prog_addr_i] <= mem_q[prog_addr_i] & prog_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  logic [7:0] cur_at_pa;
  assign cur_at_pa = mem_q[prog_addr_i];

  // R6
  prog_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_i && !erase_req_i) |=> (mem_q[$past(prog_addr_i)] & ~$past(cur_at_pa)) == 8'h00);

  // R4
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_i |=> mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int         AW        = 4,
  parameter logic [7:0] DEV_ID    = 8'hB4,
  parameter int         PROG_CYC  = 4,
  parameter int         ERASE_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          prog_hv_i,
  input  logic          id_hv_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_oe_o,
  output logic          busy_o
);

  logic          we_q;
  logic          wr_stb, wr_acc;
  flash_mode_e   mode;
  logic [AW-1:0] evfy_addr, prog_addr, arr_addr;
  logic [7:0]    prog_data, arr_data, id_code, rd_val;
  logic          erase_req, prog_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  // one write per falling edge of write enable
  assign wr_stb = !ce_ni && !we_ni && we_q && oe_ni;
  assign wr_acc = wr_stb && prog_hv_i && !busy_o;

  flash_cmd_fsm #(.AW(AW)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_acc),
    .prog_hv_i   (prog_hv_i),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .mode_o      (mode),
    .evfy_addr_o (evfy_addr),
    .prog_addr_o (prog_addr),
    .prog_data_o (prog_data),
    .erase_req_o (erase_req),
    .prog_req_o  (prog_req)
  );

  flash_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .erase_req_i (erase_req),
    .prog_req_i  (prog_req),
    .busy_o      (busy_o)
  );

  always_comb begin
    unique case (mode)
      MD_ERASE_VFY: arr_addr = evfy_addr;
      MD_PROG_VFY:  arr_addr = prog_addr;
      default:      arr_addr = addr_i;
    endcase
  end

  flash_byte_array #(.AW(AW)) i_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .erase_req_i (erase_req),
    .prog_req_i  (prog_req),
    .prog_addr_i (prog_addr),
    .prog_data_i (prog_data),
    .rd_addr_i   (arr_addr),
    .rd_data_o   (arr_data)
  );

  assign id_code = addr_i[0] ? DEV_ID : MFG_CODE;
  assign rd_val  = (id_hv_i || mode == MD_IDENT) ? id_code : arr_data;
  assign rd_oe_o = !ce_ni && !oe_ni && we_ni;
  assign rd_data_o = rd_oe_o ? rd_val : 8'h00;

  // R12
  busy_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(erase_req || prog_req));

  // R12
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_stb && prog_hv_i) |=> $stable(mode));

  // R10
  supply_low_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_hv_i |-> !(erase_req || prog_req));

endmodule

// File: tb/test_flash_cmd_if.sv
`timescale 1ns/1ps
module test_flash_cmd_if;

  localparam int         AW        = 4;
  localparam int         DEPTH     = 1 << AW;
  localparam logic [7:0] DEV_ID    = 8'hB4;
  localparam int         PROG_CYC  = 4;
  localparam int         ERASE_CYC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          vpp = 1'b1, idhv = 1'b0;
  logic [7:0]    dout;
  logic          doe, busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  flash_cmd_if #(.AW(AW), .DEV_ID(DEV_ID), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC))
  i_flash_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .prog_hv_i(vpp), .id_hv_i(idhv),
    .rd_data_o(dout), .rd_oe_o(doe), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    @(negedge clk); we_n = 1; ce_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1 d = dout;
    oe_n = 1; ce_n = 1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    int errs = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0], v);
      if (v !== model[a]) begin
        errs++;
        $display("FAIL %s addr=%0d act=%0h exp=%0h", req, a, v, model[a]);
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 rd_oe", doe, 0);
    check_all("R1 array");

    // R6 program sweep, busy length
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] pv = 8'((a * 29 + 3) & 8'hFF);
      if (pv == 8'hFF) pv = 8'hFE;
      wr(0, 8'h40);
      wr(a[AW-1:0], pv);
      busy_len(n);
      if (a == 0) chk("R6 busy", n, PROG_CYC);
      model[a] = model[a] & pv;
    end
    wr(0, 8'h00);
    check_all("R2 R6 readback");

    // R6 second pass only clears bits
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] pv = ~8'(a * 17);
      if (pv == 8'hFF) pv = 8'h7F;
      wr(0, 8'h40);
      wr(a[AW-1:0], pv);
      idle();
      model[a] = model[a] & pv;
    end
    check_all("R6 and-only");

    // R3 identifier mode, both opcodes
    for (int c = 0; c < 2; c++) begin
      wr(0, c == 0 ? 8'h80 : 8'h90);
      for (int a = 0; a < DEPTH; a++) begin
        rd(a[AW-1:0], v);
        chk("R3 ident", v, a[0] ? DEV_ID : 8'h89);
      end
    end
    wr(0, 8'hFF);
    check_all("R2 FF read");

    // R7 erase verify uses the latched address
    for (int a = 0; a < DEPTH; a++) begin
      wr(a[AW-1:0], 8'hA0);
      rd(AW'((a + 5) % DEPTH), v);
      chk("R7 erase verify", v, model[a]);
    end

    // R8 program verify
    wr(0, 8'h00);
    wr(0, 8'h40);
    wr(7, 8'hF0);
    idle();
    model[7] = model[7] & 8'hF0;
    wr(3, 8'hC0);
    rd(12, v);
    chk("R8 program verify", v, model[7]);
    rd(0, v);
    chk("R8 program verify", v, model[7]);

    // R11 id pin overrides any mode
    wr(2, 8'hA0);
    idhv = 1;
    rd(0, v); chk("R11 id pin mfg", v, 8'h89);
    rd(1, v); chk("R11 id pin dev", v, DEV_ID);
    rd(6, v); chk("R11 id pin bit0", v, 8'h89);
    idhv = 0;
    rd(9, v); chk("R7 after id pin", v, model[2]);

    // R5 erase abort
    wr(0, 8'h00);
    wr(0, 8'h20);
    wr(0, 8'h55);
    chk("R5 busy", busy, 0);
    check_all("R5 no erase");

    // R9 reset pair from program-armed and identifier modes
    wr(0, 8'h40);
    wr(0, 8'hFF);
    wr(0, 8'hFF);
    chk("R9 busy", busy, 0);
    check_all("R9 from prog arm");
    wr(0, 8'h90);
    wr(0, 8'hFF);
    wr(0, 8'hFF);
    check_all("R9 from ident");
    wr(0, 8'h20);
    wr(0, 8'hFF);
    wr(0, 8'hFF);
    chk("R9 erase arm busy", busy, 0);
    check_all("R9 from erase arm");

    // R13 long write-enable pulse counts once
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = 0; din = 8'h20;
    repeat (3) @(negedge clk);
    we_n = 1; ce_n = 1;
    chk("R13 no erase busy", busy, 0);
    wr(0, 8'h00);
    check_all("R13 array kept");

    // R10 supply low
    wr(0, 8'h80);
    @(negedge clk); vpp = 0;
    @(negedge clk);
    rd(1, v); chk("R10 mode forced", v, model[1]);
    wr(0, 8'h20);
    wr(0, 8'h20);
    chk("R10 erase busy", busy, 0);
    wr(0, 8'h40);
    wr(5, 8'h00);
    chk("R10 prog busy", busy, 0);
    wr(0, 8'h90);
    rd(0, v); chk("R10 ident ignored", v, model[0]);
    check_all("R10 array kept");
    vpp = 1;

    // R12 writes during busy ignored
    wr(0, 8'h40);
    wr(4, 8'h0F);
    model[4] = model[4] & 8'h0F;
    wr(0, 8'h80);
    idle();
    rd(0, v); chk("R12 write ignored", v, model[0]);
    wr(0, 8'h40);
    wr(6, 8'h3C);
    model[6] = model[6] & 8'h3C;
    wr(0, 8'h40);
    wr(8, 8'h00);
    idle();
    check_all("R12 second prog ignored");

    // R4 chip erase
    wr(0, 8'h20);
    wr(0, 8'h20);
    busy_len(n);
    chk("R4 busy", n, ERASE_CYC);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    check_all("R4 erased");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule